// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block is the control core of an autonomous battery charger. A handful of single-bit flags comes in: qualification flags for the input supply, the regulator, the thermistor, high-impedance requests and charge enables, plus comparator outputs that place the feedback voltage, the battery voltage and the charge current against their thresholds. From these the sequencer steps the charger through its phases: trickle, pre-charge, constant current, constant voltage, an optional top-off period, termination and automatic recharge. It reports the phase as a 3-bit code, picks the current setpoint for the power stage, gates the converter on and off, and pulses an interrupt whenever the phase changes.

Asynchronous flags are resynchronised. The threshold comparator outputs are also filtered: a new level must persist for a programmable number of timebase ticks before the sequencer acts on it. A one-second tick drives a safety timer, a constant-voltage timer and a top-off timer. The analog comparators, the power stage and the register interface sit outside this block.

Top module: `chg_cycle_seq`

## Requirements
- R1: `phase` encodes 000 not charging, 001 trickle, 010 pre-charge, 011 constant current, 100 constant voltage, 110 top-off, 111 done. Code 101 is never output, and all outputs are in the not-charging state after reset.
- R2: A cycle may start only when the input window is OK, both high-impedance requests are off, the regulator is OK, `chg_en_bit` is 1, `ce_n` is 0, there is no thermistor fault and no latched safety fault. Losing any of these returns `phase` to 000 and drops `chg_on`. After `chg_en_bit` goes low, `phase` is 000 from the next cycle on.
- R3: On start, or when a comparator changes, the entry phase is chosen as follows: trickle if the feedback is below the short threshold; else pre-charge if it is below the low-voltage threshold; else constant voltage if it has reached regulation; else constant current. Phases only move forward, in the order trickle, pre-charge, constant current, constant voltage.
- R4: `isel` is 01 in trickle, 10 in pre-charge (20 % of the programmed current), 11 in constant current, constant voltage and top-off, and 00 otherwise. `chg_on` is 1 exactly in the charging phases 001, 010, 011, 100 and 110.
- R5: Constant voltage ends through termination only while the current is below the termination threshold, the battery is not below the recharge threshold and DPM is inactive, all at the same time. The next phase is top-off if `topoff_en` is 1, otherwise done.
- R6: Top-off lasts `topoff_ticks` ticks and then moves to done.
- R7: In done, the comparators other than recharge have no effect. A battery below the recharge threshold starts a new cycle at the entry phase. Removing and then restoring `chg_en_bit` or `ce_n` also restarts a cycle.
- R8: With `cv_tmr_en` set, constant voltage moves to done after `cv_ticks` ticks, whatever the charge current.
- R9: The safety timer counts ticks while a charging phase is active. With `safe_tmr_en` set, reaching `safe_ticks` latches a fault that forces 000 and blocks restart until `chg_en_bit` goes low or `ce_n` goes high.
- R10: With `pre_en_bit` at 0, trickle and pre-charge are skipped: the entry phase is constant current whenever the feedback is below regulation.
- R11: `irq` is high for exactly the first cycle of every new `phase` value, done included.
- R12: Threshold comparator and DPM inputs pass through a two-flop synchroniser and are accepted only after differing from the accepted value for `filt_ticks` consecutive ticks. A shorter glitch causes no phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle timebase tick (one second) |
| in_win_ok | input | 1 | Input voltage inside operating window (async) |
| hiz_pin_req | input | 1 | High-impedance request from pin (async) |
| ldo_ok | input | 1 | Internal regulator OK (async) |
| ts_fault | input | 1 | Thermistor fault (async) |
| ce_n | input | 1 | Active-low chip enable (async) |
| dpm_act | input | 1 | Input DPM regulation active (async, filtered) |
| fb_below_short | input | 1 | Feedback below short threshold (async, filtered) |
| fb_below_lowv | input | 1 | Feedback below low-voltage threshold (async, filtered) |
| fb_at_reg | input | 1 | Feedback reached regulation target (async, filtered) |
| vbat_below_rechg | input | 1 | Battery below recharge threshold (async, filtered) |
| ibat_below_term | input | 1 | Charge current below termination threshold (async, filtered) |
| hiz_bit | input | 1 | High-impedance mode control bit |
| chg_en_bit | input | 1 | Charge enable control bit |
| pre_en_bit | input | 1 | Trickle and pre-charge enable |
| topoff_en | input | 1 | Top-off phase enable |
| topoff_ticks | input | PH_W | Top-off duration in ticks |
| cv_tmr_en | input | 1 | Constant-voltage timer enable |
| cv_ticks | input | PH_W | Constant-voltage timer duration in ticks |
| safe_tmr_en | input | 1 | Safety timer enable |
| safe_ticks | input | SAFE_W | Safety timer limit in ticks |
| filt_ticks | input | FILT_W | Comparator filter length in ticks |
| phase | output | 3 | Charge phase code |
| isel | output | 2 | Current setpoint select |
| chg_on | output | 1 | Converter charge enable |
| irq | output | 1 | One-cycle pulse on a phase change |

## Verification
The hardest situations to reach are the ones where the sequencer must not react: a comparator glitch that is shorter than the filter window, a termination request held off by DPM, and a latched safety fault that must block a restart even though every other start condition is valid. The stimulus parks the sequencer in a known phase, changes the comparators only while the next transition is harmless, and then applies the blocking condition. It waits well past the filter latency and checks that no interrupt arrived and that the phase did not move. The safety fault is produced by enabling the timer with a short limit during constant current. The block then sits in the fault for several limit periods before the enable is toggled to release it.

// File: rtl/chg_pkg.sv
package chg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'b000,
      PH_TRK  = 3'b001,
      PH_PRE  = 3'b010,
      PH_CC   = 3'b011,
      PH_CV   = 3'b100,
      PH_TOP  = 3'b110,
      PH_DONE = 3'b111
   } phase_e;

   typedef enum logic [1:0] {
      ISEL_OFF  = 2'b00,
      ISEL_TRK  = 2'b01,
      ISEL_PRE  = 2'b10,
      ISEL_FULL = 2'b11
   } isel_e;

   // bit positions inside the filtered comparator vector
   localparam int CMP_DPM   = 0;
   localparam int CMP_SHORT = 1;
   localparam int CMP_LOWV  = 2;
   localparam int CMP_REG   = 3;
   localparam int CMP_RECHG = 4;
   localparam int CMP_TERM  = 5;
   localparam int N_CMP     = 6;

   // bit positions inside the qualification vector
   localparam int Q_WIN  = 0;
   localparam int Q_HIZ  = 1;
   localparam int Q_LDO  = 2;
   localparam int Q_TS   = 3;
   localparam int Q_CEN  = 4;
   localparam int N_QUAL = 5;
endpackage

// File: rtl/chg_flag_cond.sv
module chg_flag_cond #(
   parameter int N      = 4,
   parameter int FILT_W = 4,
   parameter bit FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [FILT_W-1:0] filt_ticks,
   input  logic [N-1:0]      raw,
   output logic [N-1:0]      clean
);
   logic [N-1:0] meta, sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         sync <= '0;
      end else begin
         meta <= raw;
         sync <= meta;
      end
   end

   generate
      if (FILTER) begin : g_filt
         for (genvar i = 0; i < N; i++) begin : g_bit
            logic [FILT_W-1:0] cnt;
            logic              acc;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cnt <= '0;
                  acc <= 1'b0;
               end else if (sync[i] == acc) begin
                  cnt <= '0;
               end else if (filt_ticks == '0) begin
                  acc <= sync[i];
               end else if (tick) begin
                  if (cnt == filt_ticks - 1'b1) begin
                     acc <= sync[i];
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            assign clean[i] = acc;
         end
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = tick ^ (^filt_ticks);
         assign clean = sync;
      end
   endgenerate
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         reached
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (run && tick && ~&cnt)   cnt <= cnt + 1'b1;
   end

   assign reached = (cnt >= limit);
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
   import chg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic             en_removed,
   input  logic             pre_en,
   input  logic             topoff_en,
   input  logic             cv_tmr_en,
   input  logic             safe_tmr_en,
   input  logic [N_CMP-1:0] cmp,
   input  logic             ph_reached,
   input  logic             safe_reached,
   output logic             safe_fault,
   output logic             ph_clr,
   output logic             top_sel,
   output logic             charging,
   output phase_e           state,
   output logic             irq
);
   phase_e nxt, entry;
   logic   term_ok;

   always_comb begin
      if (cmp[CMP_REG])                        entry = PH_CV;
      else if (!pre_en)                        entry = PH_CC;
      else if (cmp[CMP_SHORT])                 entry = PH_TRK;
      else if (cmp[CMP_LOWV])                  entry = PH_PRE;
      else                                     entry = PH_CC;
   end

   assign term_ok = cmp[CMP_TERM] && !cmp[CMP_RECHG] && !cmp[CMP_DPM];

   always_comb begin
      nxt = state;
      if (!start_ok) begin
         nxt = PH_IDLE;
      end else begin
         case (state)
            PH_IDLE: nxt = entry;
            PH_TRK, PH_PRE, PH_CC:
               if (entry > state) nxt = entry;
            PH_CV:
               if (cv_tmr_en && ph_reached) nxt = PH_DONE;
               else if (term_ok)            nxt = topoff_en ? PH_TOP : PH_DONE;
            PH_TOP:
               if (ph_reached)              nxt = PH_DONE;
            PH_DONE:
               if (cmp[CMP_RECHG])          nxt = entry;
            default:                        nxt = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PH_IDLE;
         irq        <= 1'b0;
         safe_fault <= 1'b0;
      end else begin
         state <= nxt;
         irq   <= (nxt != state);
         if (en_removed)                        safe_fault <= 1'b0;
         else if (safe_tmr_en && safe_reached)  safe_fault <= 1'b1;
      end
   end

   assign charging = (state == PH_TRK) || (state == PH_PRE) || (state == PH_CC) ||
                     (state == PH_CV)  || (state == PH_TOP);
   assign ph_clr   = (nxt != state) || (state == PH_IDLE);
   assign top_sel  = (state == PH_TOP);
endmodule

// File: rtl/chg_cycle_seq.sv
module chg_cycle_seq
   import chg_pkg::*;
#(
   parameter int PH_W   = 16,
   parameter int SAFE_W = 16,
   parameter int FILT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1s,
   input  logic              in_win_ok,
   input  logic              hiz_pin_req,
   input  logic              ldo_ok,
   input  logic              ts_fault,
   input  logic              ce_n,
   input  logic              dpm_act,
   input  logic              fb_below_short,
   input  logic              fb_below_lowv,
   input  logic              fb_at_reg,
   input  logic              vbat_below_rechg,
   input  logic              ibat_below_term,
   input  logic              hiz_bit,
   input  logic              chg_en_bit,
   input  logic              pre_en_bit,
   input  logic              topoff_en,
   input  logic [PH_W-1:0]   topoff_ticks,
   input  logic              cv_tmr_en,
   input  logic [PH_W-1:0]   cv_ticks,
   input  logic              safe_tmr_en,
   input  logic [SAFE_W-1:0] safe_ticks,
   input  logic [FILT_W-1:0] filt_ticks,
   output logic [2:0]        phase,
   output logic [1:0]        isel,
   output logic              chg_on,
   output logic              irq
);
   generate
      if (PH_W < 2 || PH_W > 32)     begin : g_bad_ph   $error("PH_W out of range");   end
      if (SAFE_W < 2 || SAFE_W > 32) begin : g_bad_safe $error("SAFE_W out of range"); end
      if (FILT_W < 1 || FILT_W > 16) begin : g_bad_filt $error("FILT_W out of range"); end
   endgenerate

   logic [N_QUAL-1:0] q_raw, q;
   logic [N_CMP-1:0]  c_raw, c;
   logic              start_ok, en_removed, safe_fault, ph_clr, top_sel, charging;
   logic              ph_reached, safe_reached;
   logic [PH_W-1:0]   ph_limit;
   phase_e            state;

   assign q_raw = {ce_n, ts_fault, ldo_ok, hiz_pin_req, in_win_ok};
   assign c_raw = {ibat_below_term, vbat_below_rechg, fb_at_reg,
                   fb_below_lowv, fb_below_short, dpm_act};

   chg_flag_cond #(.N(N_QUAL), .FILT_W(FILT_W), .FILTER(1'b0)) u_qual (
      .clk(clk), .rst_n(rst_n), .tick(tick_1s), .filt_ticks(filt_ticks),
      .raw(q_raw), .clean(q));

   chg_flag_cond #(.N(N_CMP), .FILT_W(FILT_W), .FILTER(1'b1)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick_1s), .filt_ticks(filt_ticks),
      .raw(c_raw), .clean(c));

   assign en_removed = !chg_en_bit || q[Q_CEN];
   assign start_ok   = q[Q_WIN] && !q[Q_HIZ] && !hiz_bit && q[Q_LDO] &&
                       !q[Q_TS] && !en_removed && !safe_fault;
   assign ph_limit   = top_sel ? topoff_ticks : cv_ticks;

   chg_tick_timer #(.W(PH_W)) u_ph_tmr (
      .clk(clk), .rst_n(rst_n), .clr(ph_clr), .run(1'b1), .tick(tick_1s),
      .limit(ph_limit), .reached(ph_reached));

   chg_tick_timer #(.W(SAFE_W)) u_safe_tmr (
      .clk(clk), .rst_n(rst_n), .clr(state == PH_IDLE), .run(charging),
      .tick(tick_1s), .limit(safe_ticks), .reached(safe_reached));

   chg_phase_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .en_removed(en_removed),
      .pre_en(pre_en_bit), .topoff_en(topoff_en), .cv_tmr_en(cv_tmr_en),
      .safe_tmr_en(safe_tmr_en), .cmp(c), .ph_reached(ph_reached),
      .safe_reached(safe_reached), .safe_fault(safe_fault), .ph_clr(ph_clr),
      .top_sel(top_sel), .charging(charging), .state(state), .irq(irq));

   always_comb begin
      case (state)
         PH_TRK:                isel = ISEL_TRK;
         PH_PRE:                isel = ISEL_PRE;
         PH_CC, PH_CV, PH_TOP:  isel = ISEL_FULL;
         default:               isel = ISEL_OFF;
      endcase
   end

   assign phase  = state;
   assign chg_on = charging;
endmodule

// File: rtl/chg_cycle_seq_chk.sv
module chg_cycle_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chg_en_bit,
   input logic [2:0] phase,
   input logic [1:0] isel,
   input logic       chg_on,
   input logic       irq
);
   a_r1_no_rsvd_code: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 3'b101);

   a_r2_en_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_en_bit |=> phase == 3'b000);

   a_r2_idle_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'b000 || phase == 3'b111) |-> !chg_on);

   a_r4_pre_setpoint: assert property (@(posedge clk) disable iff (!rst_n)
      phase == 3'b010 |-> isel == 2'b10);

   a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'b111 && $past(phase) != 3'b111) |->
         ($past(phase) == 3'b100 || $past(phase) == 3'b110));

   a_r11_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (phase != $past(phase)));
endmodule

bind chg_cycle_seq chg_cycle_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chg_en_bit(chg_en_bit), .phase(phase),
   .isel(isel), .chg_on(chg_on), .irq(irq));

// File: tb/tb_chg_cycle_seq.sv
`timescale 1ns/1ps
module tb_chg_cycle_seq;
   localparam int PH_W = 16, SAFE_W = 16, FILT_W = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0;
   logic in_win_ok = 0, hiz_pin_req = 0, ldo_ok = 0, ts_fault = 0, ce_n = 0;
   logic dpm_act = 0, fb_below_short = 0, fb_below_lowv = 0, fb_at_reg = 0;
   logic vbat_below_rechg = 0, ibat_below_term = 0;
   logic hiz_bit = 0, chg_en_bit = 0, pre_en_bit = 1, topoff_en = 0;
   logic cv_tmr_en = 0, safe_tmr_en = 0;
   logic [PH_W-1:0]   topoff_ticks = 2, cv_ticks = 3;
   logic [SAFE_W-1:0] safe_ticks = 10;
   logic [FILT_W-1:0] filt_ticks = 2;
   logic [2:0] phase;
   logic [1:0] isel;
   logic chg_on, irq;

   int n_chk = 0, n_err = 0;
   logic [2:0] exp_ph[$];
   string      exp_tag[$];

   always #2.5 clk = ~clk;

   chg_cycle_seq #(.PH_W(PH_W), .SAFE_W(SAFE_W), .FILT_W(FILT_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .in_win_ok(in_win_ok),
      .hiz_pin_req(hiz_pin_req), .ldo_ok(ldo_ok), .ts_fault(ts_fault),
      .ce_n(ce_n), .dpm_act(dpm_act), .fb_below_short(fb_below_short),
      .fb_below_lowv(fb_below_lowv), .fb_at_reg(fb_at_reg),
      .vbat_below_rechg(vbat_below_rechg), .ibat_below_term(ibat_below_term),
      .hiz_bit(hiz_bit), .chg_en_bit(chg_en_bit), .pre_en_bit(pre_en_bit),
      .topoff_en(topoff_en), .topoff_ticks(topoff_ticks), .cv_tmr_en(cv_tmr_en),
      .cv_ticks(cv_ticks), .safe_tmr_en(safe_tmr_en), .safe_ticks(safe_ticks),
      .filt_ticks(filt_ticks), .phase(phase), .isel(isel), .chg_on(chg_on),
      .irq(irq));

   function automatic logic [1:0] exp_isel(logic [2:0] p);
      case (p)
         3'b001: return 2'b01;
         3'b010: return 2'b10;
         3'b011, 3'b100, 3'b110: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic exp_on(logic [2:0] p);
      return (p == 3'b001 || p == 3'b010 || p == 3'b011 || p == 3'b100 || p == 3'b110);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_ph(logic [2:0] p, string tag);
      exp_ph.push_back(p);
      exp_tag.push_back(tag);
   endtask

   task automatic drain(string tag);
      int n = 0;
      while (exp_ph.size() != 0 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(exp_ph.size() == 0, {tag, " phase change not seen"}, exp_ph.size(), 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor: every interrupt must match the next expected phase
   always @(negedge clk) begin
      if (rst_n && irq) begin
         if (exp_ph.size() == 0) begin
            chk(1'b0, "R11 unexpected phase change", phase, -1);
         end else begin
            automatic logic [2:0] e = exp_ph.pop_front();
            automatic string t = exp_tag.pop_front();
            chk(phase == e, {t, " phase"}, phase, e);
            chk(isel == exp_isel(e), "R4 isel", isel, exp_isel(e));
            chk(chg_on == exp_on(e), "R4 chg_on", chg_on, exp_on(e));
         end
      end
   end

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick_1s = 1'b1;
         @(negedge clk);
         tick_1s = 1'b0;
      end
   end

   initial begin
      #(200000 * 5);
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      idle(4);
      chk(phase == 3'b000, "R1 reset phase", phase, 0);
      chk(isel == 2'b00 && !chg_on && !irq, "R1 reset outputs", {isel, chg_on, irq}, 0);
      @(negedge clk) rst_n = 1'b1;

      // R3: trickle -> pre -> CC -> CV, R5: plain termination
      fb_below_short = 1; fb_below_lowv = 1;
      idle(30);
      expect_ph(3'b001, "R3 trickle");
      in_win_ok = 1; ldo_ok = 1; chg_en_bit = 1;
      drain("R2 start");
      fb_below_short = 0; expect_ph(3'b010, "R3 pre"); drain("R3");
      fb_below_lowv = 0;  expect_ph(3'b011, "R3 cc");  drain("R3");
      fb_at_reg = 1;      expect_ph(3'b100, "R3 cv");  drain("R3");
      ibat_below_term = 1; expect_ph(3'b111, "R5 done"); drain("R5");
      chk(!chg_on, "R4 chg_on in done", chg_on, 0);

      // R7: done ignores other comparators, recharge restarts
      ibat_below_term = 0; fb_at_reg = 0;
      idle(40);
      chk(phase == 3'b111, "R7 done holds", phase, 7);
      vbat_below_rechg = 1; expect_ph(3'b011, "R7 recharge cc"); drain("R7");
      vbat_below_rechg = 0; fb_at_reg = 1; expect_ph(3'b100, "R3 cv"); drain("R3");

      // R5: DPM blocks termination; R6: top-off
      dpm_act = 1; ibat_below_term = 1;
      idle(50);
      chk(phase == 3'b100, "R5 dpm blocks term", phase, 4);
      topoff_en = 1;
      expect_ph(3'b110, "R6 topoff"); expect_ph(3'b111, "R6 done");
      dpm_act = 0;
      drain("R6");
      topoff_en = 0;

      // R7: enable bit toggle restarts
      expect_ph(3'b000, "R2 en removed");
      chg_en_bit = 0; drain("R2");
      chk(!chg_on, "R2 chg_on off", chg_on, 0);
      expect_ph(3'b100, "R7 restart cv"); expect_ph(3'b111, "R5 done");
      chg_en_bit = 1; drain("R7");

      // R8: CV timer ends charging with current still high
      ibat_below_term = 0; idle(30);
      cv_tmr_en = 1;
      expect_ph(3'b000, "R2 ce_n high"); ce_n = 1; drain("R2");
      expect_ph(3'b100, "R7 ce restart"); expect_ph(3'b111, "R8 cv timer done");
      ce_n = 0; drain("R8");
      cv_tmr_en = 0;

      // R10: supercap bypass
      fb_at_reg = 0; fb_below_short = 1; fb_below_lowv = 1; idle(30);
      pre_en_bit = 0;
      expect_ph(3'b000, "R2"); chg_en_bit = 0; drain("R2");
      expect_ph(3'b011, "R10 bypass cc"); chg_en_bit = 1; drain("R10");
      chk(isel == 2'b11, "R10 full current", isel, 3);

      // R12: short glitch on regulation comparator is ignored
      @(negedge clk) fb_at_reg = 1;
      idle(3);
      fb_at_reg = 0;
      idle(50);
      chk(phase == 3'b011 && exp_ph.size() == 0, "R12 glitch ignored", phase, 3);

      // R9: safety timer fault latches and blocks restart
      expect_ph(3'b000, "R9 safety fault");
      safe_tmr_en = 1; drain("R9");
      idle(120);
      chk(phase == 3'b000, "R9 no restart under fault", phase, 0);
      safe_tmr_en = 0;
      chg_en_bit = 0; idle(10);
      expect_ph(3'b011, "R9 restart after toggle");
      chg_en_bit = 1; drain("R9");

      // R2: thermistor fault and high-impedance pin
      expect_ph(3'b000, "R2 thermistor"); ts_fault = 1; drain("R2");
      chk(!chg_on && isel == 2'b00, "R2 thermistor outputs off", {chg_on, isel}, 0);
      expect_ph(3'b011, "R2 resume"); ts_fault = 0; drain("R2");
      expect_ph(3'b000, "R2 hiz pin"); hiz_pin_req = 1; drain("R2");
      expect_ph(3'b011, "R2 resume"); hiz_pin_req = 0; drain("R2");
      expect_ph(3'b000, "R2 hiz bit"); hiz_bit = 1; drain("R2");
      hiz_bit = 0; expect_ph(3'b011, "R2 resume"); drain("R2");

      idle(20);
      chk(exp_ph.size() == 0, "R11 scoreboard empty", exp_ph.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule